// File: doc/BRIEF.md
# Debug-Port Instruction Stream Tracker

This block follows the instruction protocol of a two-wire debug and programming port. It sits behind a frame receiver that hands it one validated byte at a time, plus a strobe for each line-break condition. The first byte of an instruction is an opcode. The tracker decodes that byte and works out how many address and data bytes follow. It also works out which way each item travels: from the programmer to the device, or back. It then gathers the following bytes into items of 1 to 4 bytes, or a single 8-byte unlock key, and reports each completed item together with its width and direction.

A repeat instruction stores a count N. The next indirect load or indirect store then moves N+1 data items instead of one, and the stored count returns to zero. A break abandons whatever instruction is in progress, clears the stored count and reports an aborted end of instruction. The byte that follows a break is always taken as a fresh opcode. All outputs are registered, so each result appears one clock after the byte or break that caused it. The opcode fields stay on the outputs until the next opcode arrives.

Top module: `dbg_insn_tracker`

## Requirements
- R1: After reset, every strobe output is low, the opcode fields read zero, and the stored repeat count is zero.
- R2: When no instruction is in progress, an accepted byte is an opcode. Bits 7:5 give its code: 0 direct load, 1 indirect load, 2 direct store, 3 indirect store, 4 control load, 5 repeat, 6 control store, 7 unlock key. `op_vld` pulses one clock later, with the decoded fields on the outputs.
- R3: For direct load and direct store, bits 3:2 plus one give `addr_size` and bits 1:0 plus one give `data_size`. The address item comes first and is written (`item_dir`=0). The single data item is then read (`item_dir`=1) for the direct load and written for the direct store.
- R4: For indirect load and indirect store, `op_arg` carries bits 3:2 as the pointer mode, `data_size` is bits 1:0 plus one, and `addr_size` is 0. The data items are read for the load and written for the store.
- R5: For control load and control store, `op_arg` carries bits 3:0 as the register index. Exactly one 1-byte item follows: read for the load, written for the store.
- R6: The unlock key opcode is followed by exactly eight written bytes, reported as one item of width 8.
- R7: Multi-byte items are assembled least-significant byte first, and the unused upper bits of `item_data` are zero.
- R8: After a repeat instruction with value N, the next indirect load or store produces N+1 data items and then clears the count to zero, so a later indirect access produces one item. The repeat width field (bits 1:0 plus one) sets the byte count of N.
- R9: A stored repeat count survives instructions that are neither indirect load nor indirect store.
- R10: A break strobe ends any instruction in progress. One clock later `insn_done` and `insn_abort` are high. The repeat count is cleared, and the next byte is decoded as an opcode.
- R11: When a break and a byte arrive in the same cycle, the break wins and the byte is discarded: no item and no opcode is reported for it.
- R12: A normal end of instruction raises `insn_done` with `insn_abort` low in the same cycle as the strobe of the instruction's last item.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A validated byte is present |
| byte_data | input | 8 | Byte value |
| brk_stb | input | 1 | Line-break condition seen |
| op_vld | output | 1 | Opcode decoded (one-cycle pulse) |
| op_code | output | 3 | Decoded opcode |
| addr_size | output | 3 | Address bytes (0 when none) |
| data_size | output | 4 | Bytes per data item |
| op_arg | output | 4 | Pointer mode or register index |
| item_vld | output | 1 | Completed item strobe |
| item_data | output | 64 | Assembled item value |
| item_width | output | 4 | Width of the item in bytes |
| item_dir | output | 1 | 1 = device to programmer, 0 = programmer to device |
| insn_done | output | 1 | Instruction finished or aborted |
| insn_abort | output | 1 | Finish was caused by a break |

## Verification
Two events can land in the same cycle: a break strobe, and the byte that would complete an instruction. The bench provokes this by driving both together on the only data byte of a control store. It requires the abort report, no item strobe and no normal completion. It also requires that the next byte decodes as a fresh opcode. A second case shows that completion and the last item coincide: the bench judges `insn_done` by sampling it in the very cycle that carries the last item strobe.

// File: rtl/dbg_insn_pkg.sv
package dbg_insn_pkg;

    localparam int KEY_LEN = 8;

    typedef enum logic [2:0] {
        OPC_LD_DIR = 3'd0,
        OPC_LD_IND = 3'd1,
        OPC_ST_DIR = 3'd2,
        OPC_ST_IND = 3'd3,
        OPC_LD_CTL = 3'd4,
        OPC_RPT    = 3'd5,
        OPC_ST_CTL = 3'd6,
        OPC_UNLOCK = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        opc_e       opcode;
        logic [2:0] asz;
        logic [3:0] dsz;
        logic [3:0] arg;
        logic       has_addr;
        logic       rd;
        logic       uses_rep;
        logic       is_rep;
    } op_info_t;

endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
    import dbg_insn_pkg::*;
(
    input  logic [2:0] opc_bits,
    input  logic [3:0] low_bits,
    output op_info_t   info
);
    always_comb begin
        info          = '0;
        info.opcode   = opc_e'(opc_bits);
        info.dsz      = {2'b00, low_bits[1:0]} + 4'd1;
        case (opc_e'(opc_bits))
            OPC_LD_DIR, OPC_ST_DIR: begin
                info.has_addr = 1'b1;
                info.asz      = {1'b0, low_bits[3:2]} + 3'd1;
                info.rd       = (opc_bits == OPC_LD_DIR);
            end
            OPC_LD_IND, OPC_ST_IND: begin
                info.arg      = {2'b00, low_bits[3:2]};
                info.uses_rep = 1'b1;
                info.rd       = (opc_bits == OPC_LD_IND);
            end
            OPC_LD_CTL, OPC_ST_CTL: begin
                info.arg = low_bits;
                info.dsz = 4'd1;
                info.rd  = (opc_bits == OPC_LD_CTL);
            end
            OPC_RPT:    info.is_rep = 1'b1;
            OPC_UNLOCK: info.dsz    = 4'(KEY_LEN);
            default:    info.dsz    = 4'd1;
        endcase
    end
endmodule

// File: rtl/dbg_item_merge.sv
module dbg_item_merge #(
    parameter int NBYTES = 8,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic [NBYTES*8-1:0] acc_in,
    input  logic [IDX_W-1:0]    lane,
    input  logic [7:0]          byte_in,
    output logic [NBYTES*8-1:0] acc_out
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign acc_out[k*8 +: 8] = (lane == IDX_W'(k)) ? byte_in : acc_in[k*8 +: 8];
    end
endmodule

// File: rtl/dbg_insn_tracker.sv
module dbg_insn_tracker
    import dbg_insn_pkg::*;
#(
    parameter int REP_W = 32,
    localparam int ACC_W = KEY_LEN * 8,
    localparam int IDX_W = $clog2(KEY_LEN),
    localparam int WID_W = $clog2(KEY_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             brk_stb,
    output logic             op_vld,
    output logic [2:0]       op_code,
    output logic [2:0]       addr_size,
    output logic [3:0]       data_size,
    output logic [3:0]       op_arg,
    output logic             item_vld,
    output logic [ACC_W-1:0] item_data,
    output logic [WID_W-1:0] item_width,
    output logic             item_dir,
    output logic             insn_done,
    output logic             insn_abort
);
    typedef struct packed {
        phase_e             ph;
        op_info_t           info;
        logic [IDX_W-1:0]   idx;
        logic [REP_W-1:0]   more;
        logic [REP_W-1:0]   rep;
        logic [ACC_W-1:0]   acc;
        logic               op_vld;
        logic               item_vld;
        logic [ACC_W-1:0]   item_data;
        logic [WID_W-1:0]   item_width;
        logic               item_dir;
        logic               done;
        logic               abort;
    } state_t;

    state_t     st_d, st_q;
    op_info_t   dec_info;
    logic [ACC_W-1:0] merged;
    logic [WID_W-1:0] cur_w;
    logic             last_byte;

    dbg_op_decode u_dec (
        .opc_bits (byte_data[7:5]),
        .low_bits (byte_data[3:0]),
        .info     (dec_info)
    );

    dbg_item_merge #(.NBYTES(KEY_LEN)) u_merge (
        .acc_in  (st_q.acc),
        .lane    (st_q.idx),
        .byte_in (byte_data),
        .acc_out (merged)
    );

    always_comb begin
        cur_w     = (st_q.ph == PH_ADDR) ? WID_W'(st_q.info.asz) : WID_W'(st_q.info.dsz);
        last_byte = (WID_W'(st_q.idx) + WID_W'(1)) == cur_w;

        st_d          = st_q;
        st_d.op_vld   = 1'b0;
        st_d.item_vld = 1'b0;
        st_d.done     = 1'b0;
        st_d.abort    = 1'b0;

        if (brk_stb) begin
            st_d.ph    = PH_OPC;
            st_d.rep   = '0;
            st_d.more  = '0;
            st_d.idx   = '0;
            st_d.acc   = '0;
            st_d.done  = 1'b1;
            st_d.abort = 1'b1;
        end else if (byte_vld) begin
            if (st_q.ph == PH_OPC) begin
                st_d.info   = dec_info;
                st_d.op_vld = 1'b1;
                st_d.idx    = '0;
                st_d.acc    = '0;
                st_d.ph     = dec_info.has_addr ? PH_ADDR : PH_DATA;
                if (dec_info.uses_rep) begin
                    st_d.more = st_q.rep;
                    st_d.rep  = '0;
                end else begin
                    st_d.more = '0;
                end
            end else if (last_byte) begin
                st_d.item_vld   = 1'b1;
                st_d.item_data  = merged;
                st_d.item_width = cur_w;
                st_d.item_dir   = (st_q.ph == PH_DATA) && st_q.info.rd;
                st_d.idx        = '0;
                st_d.acc        = '0;
                if (st_q.ph == PH_ADDR) begin
                    st_d.ph = PH_DATA;
                end else if (st_q.more == '0) begin
                    st_d.done = 1'b1;
                    st_d.ph   = PH_OPC;
                    if (st_q.info.is_rep) begin
                        st_d.rep = merged[REP_W-1:0];
                    end
                end else begin
                    st_d.more = st_q.more - REP_W'(1);
                end
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
                st_d.acc = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_vld     = st_q.op_vld;
    assign op_code    = st_q.info.opcode;
    assign addr_size  = st_q.info.asz;
    assign data_size  = st_q.info.dsz;
    assign op_arg     = st_q.info.arg;
    assign item_vld   = st_q.item_vld;
    assign item_data  = st_q.item_data;
    assign item_width = st_q.item_width;
    assign item_dir   = st_q.item_dir;
    assign insn_done  = st_q.done;
    assign insn_abort = st_q.abort;
endmodule

// File: rtl/dbg_insn_tracker_chk.sv
module dbg_insn_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       brk_stb,
    input logic       op_vld,
    input logic [2:0] op_code,
    input logic       item_vld,
    input logic [3:0] item_width,
    input logic       insn_done,
    input logic       insn_abort
);
    AST_BREAK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_stb |=> (insn_done && insn_abort)); // R10

    AST_BREAK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_stb && byte_vld) |=> (!item_vld && !op_vld)); // R11

    AST_DONE_WITH_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !insn_abort) |-> item_vld); // R12

    AST_OPC_NOT_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> !item_vld); // R2

    AST_KEY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (item_vld && op_code == 3'd7) |-> item_width == 4'd8); // R6

    AST_CTL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (item_vld && (op_code == 3'd4 || op_code == 3'd6)) |-> item_width == 4'd1); // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!op_vld && !item_vld && !insn_done)); // R1
endmodule

bind dbg_insn_tracker dbg_insn_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .brk_stb    (brk_stb),
    .op_vld     (op_vld),
    .op_code    (op_code),
    .item_vld   (item_vld),
    .item_width (item_width),
    .insn_done  (insn_done),
    .insn_abort (insn_abort)
);

// File: tb/dbg_insn_tracker_tb.sv
module dbg_insn_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        brk_stb = 1'b0;
    logic        op_vld;
    logic [2:0]  op_code;
    logic [2:0]  addr_size;
    logic [3:0]  data_size;
    logic [3:0]  op_arg;
    logic        item_vld;
    logic [63:0] item_data;
    logic [3:0]  item_width;
    logic        item_dir;
    logic        insn_done;
    logic        insn_abort;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_insn_tracker u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // drive one cycle; outputs are sampled at the following falling edge
    task automatic cyc(input logic v, input logic [7:0] b, input logic brk);
        @(negedge clk);
        byte_vld = v; byte_data = b; brk_stb = brk;
        @(negedge clk);
        byte_vld = 1'b0; brk_stb = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        cyc(1'b1, b, 1'b0);
    endtask

    task automatic expect_item(input string tag, input logic [63:0] d, input logic [3:0] w,
                               input logic dir, input logic done);
        eq({tag, " item_vld"}, item_vld, 1'b1);
        eq({tag, " item_data"}, item_data, d);
        eq({tag, " item_width"}, item_width, w);
        eq({tag, " item_dir"}, item_dir, dir);
        eq({tag, " insn_done"}, insn_done, done);
        eq({tag, " insn_abort"}, insn_abort, 1'b0);
    endtask

    task automatic t_reset();
        eq("R1 op_vld", op_vld, 0);
        eq("R1 item_vld", item_vld, 0);
        eq("R1 insn_done", insn_done, 0);
        eq("R1 op_code", op_code, 0);
        put(8'h20); put(8'h99); // indirect load with zero stored count
        expect_item("R1 rep zero", 64'h99, 1, 1, 1);
    endtask

    task automatic t_direct_load();
        put(8'h06);
        eq("R2 op_vld", op_vld, 1);
        eq("R2 op_code", op_code, 0);
        eq("R3 addr_size", addr_size, 2);
        eq("R3 data_size", data_size, 3);
        put(8'h34);
        eq("R7 no item mid", item_vld, 0);
        put(8'h12);
        expect_item("R3 lds addr", 64'h1234, 2, 0, 0);
        put(8'hAA); put(8'hBB); put(8'hCC);
        expect_item("R12 lds data", 64'hCCBBAA, 3, 1, 1);
    endtask

    task automatic t_direct_store();
        put(8'h4D);
        eq("R2 sts code", op_code, 2);
        eq("R3 sts asz", addr_size, 4);
        eq("R3 sts dsz", data_size, 2);
        put(8'h01); put(8'h02); put(8'h03); put(8'h04);
        expect_item("R7 sts addr", 64'h04030201, 4, 0, 0);
        put(8'hEF); put(8'hBE);
        expect_item("R3 sts data", 64'hBEEF, 2, 0, 1);
    endtask

    task automatic t_control();
        put(8'h82);
        eq("R5 ldcs code", op_code, 4);
        eq("R5 ldcs arg", op_arg, 2);
        put(8'h5A);
        expect_item("R5 ldcs", 64'h5A, 1, 1, 1);
        put(8'hCB);
        eq("R5 stcs code", op_code, 6);
        eq("R5 stcs arg", op_arg, 11);
        put(8'hC3);
        expect_item("R5 stcs", 64'hC3, 1, 0, 1);
    endtask

    task automatic t_key();
        put(8'hE0);
        eq("R6 key code", op_code, 7);
        for (int i = 1; i <= 7; i++) begin
            put(8'(i * 8'h11));
            eq("R6 key not early", item_vld | insn_done, 0);
        end
        put(8'h88);
        expect_item("R6 key", 64'h8877665544332211, 8, 0, 1);
    endtask

    task automatic t_repeat();
        put(8'hA0); put(8'h02);
        expect_item("R8 rpt", 64'h02, 1, 0, 1);
        put(8'hC0); put(8'h11); // control store in between
        expect_item("R9 hold", 64'h11, 1, 0, 1);
        put(8'h24);
        eq("R4 ld code", op_code, 1);
        eq("R4 ld mode", op_arg, 1);
        eq("R4 ld asz", addr_size, 0);
        for (int i = 0; i < 3; i++) begin
            put(8'(8'h40 + i));
            expect_item("R8 ld item", 64'(8'h40 + i), 1, 1, (i == 2));
        end
        put(8'h20); put(8'h77);
        expect_item("R8 cleared", 64'h77, 1, 1, 1);
        put(8'hA1); put(8'h01); put(8'h00);
        expect_item("R8 rpt2", 64'h0001, 2, 0, 1);
        put(8'h69);
        eq("R4 st mode", op_arg, 2);
        eq("R4 st dsz", data_size, 2);
        put(8'h22); put(8'h11);
        expect_item("R4 st item0", 64'h1122, 2, 0, 0);
        put(8'h44); put(8'h33);
        expect_item("R4 st item1", 64'h3344, 2, 0, 1);
    endtask

    task automatic t_break();
        put(8'h00); put(8'h10);
        expect_item("R10 lds addr", 64'h10, 1, 0, 0);
        cyc(1'b0, 8'h00, 1'b1);
        eq("R10 done", insn_done, 1);
        eq("R10 abort", insn_abort, 1);
        eq("R10 no item", item_vld, 0);
        put(8'h82);
        eq("R10 new opcode", op_vld, 1);
        eq("R10 new code", op_code, 4);
        cyc(1'b0, 8'h00, 1'b1);
        put(8'hA0); put(8'h03);
        cyc(1'b0, 8'h00, 1'b1);
        put(8'h20); put(8'h55);
        expect_item("R10 rep cleared", 64'h55, 1, 1, 1);
    endtask

    task automatic t_collide();
        put(8'hC0);
        cyc(1'b1, 8'h77, 1'b1);
        eq("R11 abort", insn_abort, 1);
        eq("R11 done", insn_done, 1);
        eq("R11 no item", item_vld, 0);
        eq("R11 no op", op_vld, 0);
        put(8'hE0);
        eq("R11 next is opcode", op_vld, 1);
        eq("R11 next code", op_code, 7);
        cyc(1'b0, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_load();
        t_direct_store();
        t_control();
        t_key();
        t_repeat();
        t_break();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule